// File: doc/BRIEF.md
# Three-Step Combination Lock Controller

This block guards a door with a fixed three-value code. A keypad front end delivers one value at a time on a 4-bit input and pulses a strobe for one clock cycle when the value is valid. The controller compares each strobed value against the code digit for the current step. A correct digit moves it one step forward. A wrong digit drops it into a lockout state. After the third correct digit the door output rises. Both the open state and the lockout state hold until reset.

The three code digits are parameters, with 3, 4 and 2 as the defaults. A one-hot selector picks the expected digit for the comparator. The selector is wired straight from the low three bits of a 4-bit state register. The door output is wired straight from the top bit of that register, so no output decode logic sits between the state and the pins. The selector is also driven out of the block, so the progress of an entry can be seen at the ports.

Top module: `combo_lock_ctrl`

## Requirements
- R1: After a cycle with `rst` high, `step_sel` is 3'b001 (first digit expected) and `door_open` is 0.
- R2: `rst` is synchronous and overrides every other input in any state: a strobe in the same cycle as reset is ignored, and the block reaches the first step at the next edge.
- R3: In any of the three entry steps, a cycle without `key_strobe` leaves `step_sel` and `door_open` unchanged.
- R4: In an entry step, a strobed value equal to the expected digit advances the block by one step at the next edge. `step_sel` goes 001 -> 010 -> 100, and the third correct digit gives `door_open`=1 with `step_sel`=000.
- R5: In an entry step, a strobed value that differs from the expected digit sends the block to lockout at the next edge. Lockout shows `step_sel`=000 and `door_open`=0.
- R6: The open state is sticky. While open, no strobe or value changes `door_open`=1 or `step_sel`=000 until reset.
- R7: Lockout is sticky. While locked out, even the full correct code leaves `door_open`=0 and `step_sel`=000 until reset.
- R8: The state is 4 bits, encoded as step1=0001, step2=0010, step3=0100, open=1000 and lockout=0000. `step_sel` equals state bits [2:0], where 001 selects digit 1, 010 digit 2 and 100 digit 3. `door_open` equals state bit 3, so at most one of the four output bits is high.
- R9: The code digits come from parameters. The defaults are 3, 4 and 2, entered in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the first entry step |
| key_val | input | 4 | Entered code value |
| key_strobe | input | 1 | One-cycle pulse marking `key_val` as a new entry |
| step_sel | output | 3 | One-hot select of the expected digit (state bits [2:0]) |
| door_open | output | 1 | High only in the open state (state bit 3) |

## Verification
Reset and a key strobe can arrive in the same cycle, and the bench provokes this collision in every state. It holds a strobe high with a value equal to the digit the current step expects, so that if the comparator path won, the block would visibly advance. After the collision the bench expects the first-step select and a closed door, which shows that reset took priority. A second overlap is a strobe that arrives while the block is open or locked out. The bench judges it by watching that neither output moves, whatever value comes with the strobe.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int KEY_W    = 4;
    localparam int N_STEPS  = 3;
    localparam int STATE_W  = N_STEPS + 1;

    typedef enum logic [STATE_W-1:0] {
        ST_LOCKOUT = 4'b0000,
        ST_STEP1   = 4'b0001,
        ST_STEP2   = 4'b0010,
        ST_STEP3   = 4'b0100,
        ST_OPEN    = 4'b1000
    } lock_state_t;

    typedef struct packed {
        logic             strobe;
        logic [KEY_W-1:0] value;
    } key_entry_t;

    function automatic logic in_entry(input lock_state_t s);
        return |s[N_STEPS-1:0];
    endfunction

endpackage

// File: rtl/digit_select.sv
module digit_select #(
    parameter int KEY_W   = 4,
    parameter int N_STEPS = 3,
    parameter logic [N_STEPS*KEY_W-1:0] CODES = '0
) (
    input  logic [N_STEPS-1:0] sel,
    output logic [KEY_W-1:0]   expected
);
    logic [KEY_W-1:0] gated [N_STEPS];

    for (genvar i = 0; i < N_STEPS; i++) begin : g_leg
        assign gated[i] = sel[i] ? CODES[i*KEY_W +: KEY_W] : '0;
    end

    always_comb begin
        expected = '0;
        for (int i = 0; i < N_STEPS; i++) expected = expected | gated[i];
    end

    always_comb begin
        // R8
        sel_onehot_chk: assert ($onehot0(sel) || $isunknown(sel));
    end
endmodule

// File: rtl/digit_compare.sv
module digit_compare #(
    parameter int KEY_W = 4
) (
    input  logic [KEY_W-1:0] entered,
    input  logic [KEY_W-1:0] expected,
    output logic             match
);
    assign match = (entered == expected);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  key_entry_t  entry,
    input  logic        match,
    output lock_state_t state
);
    lock_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STEP1: if (entry.strobe) nxt = match ? ST_STEP2 : ST_LOCKOUT;
            ST_STEP2: if (entry.strobe) nxt = match ? ST_STEP3 : ST_LOCKOUT;
            ST_STEP3: if (entry.strobe) nxt = match ? ST_OPEN  : ST_LOCKOUT;
            ST_OPEN:    nxt = ST_OPEN;
            ST_LOCKOUT: nxt = ST_LOCKOUT;
            default:    nxt = ST_LOCKOUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_STEP1;
        else     state <= nxt;
    end

    // R2
    reset_wins_chk: assert property (@(posedge clk) rst |=> state == ST_STEP1);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_entry(state) && !entry.strobe) |=> $stable(state));

    // R5
    wrong_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_entry(state) && entry.strobe && !match) |=> state == ST_LOCKOUT);

    // R6
    open_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_OPEN |=> state == ST_OPEN);

    // R7
    lockout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOCKOUT |=> state == ST_LOCKOUT);
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter logic [KEY_W-1:0] DIGIT1 = 4'd3,
    parameter logic [KEY_W-1:0] DIGIT2 = 4'd4,
    parameter logic [KEY_W-1:0] DIGIT3 = 4'd2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_val,
    input  logic             key_strobe,
    output logic [2:0]       step_sel,
    output logic             door_open
);
    localparam logic [N_STEPS*KEY_W-1:0] CODES = {DIGIT3, DIGIT2, DIGIT1};

    lock_state_t      state;
    key_entry_t       entry;
    logic [KEY_W-1:0] expected;
    logic             match;

    assign entry = '{strobe: key_strobe, value: key_val};

    digit_select #(.KEY_W(KEY_W), .N_STEPS(N_STEPS), .CODES(CODES)) u_sel (
        .sel      (state[N_STEPS-1:0]),
        .expected (expected)
    );

    digit_compare #(.KEY_W(KEY_W)) u_cmp (
        .entered  (entry.value),
        .expected (expected),
        .match    (match)
    );

    lock_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .entry (entry),
        .match (match),
        .state (state)
    );

    assign step_sel  = state[N_STEPS-1:0];
    assign door_open = state[STATE_W-1];

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (key_strobe && step_sel == 3'b100 && key_val == DIGIT3) |=> door_open);

    // R8
    out_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({door_open, step_sel}) <= 1);
endmodule

// File: tb/combo_lock_ctrl_bench.sv
module combo_lock_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] key_val = '0;
    logic       key_strobe = 1'b0;
    logic [2:0] step_sel;
    logic       door_open;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] model = 4'b0001;
    logic [3:0] code [3];
    bit done = 0;

    always #5 clk = ~clk;

    combo_lock_ctrl u_combo_lock_ctrl (
        .clk(clk), .rst(rst), .key_val(key_val), .key_strobe(key_strobe),
        .step_sel(step_sel), .door_open(door_open)
    );

    function automatic logic [3:0] ref_next(logic [3:0] s, logic r, logic st, logic [3:0] v);
        if (r) return 4'b0001;
        case (s)
            4'b0001: return !st ? s : (v == code[0] ? 4'b0010 : 4'b0000);
            4'b0010: return !st ? s : (v == code[1] ? 4'b0100 : 4'b0000);
            4'b0100: return !st ? s : (v == code[2] ? 4'b1000 : 4'b0000);
            default: return s;
        endcase
    endfunction

    task automatic cycle(input logic r, input logic st, input logic [3:0] v, input string tag);
        @(negedge clk);
        rst = r; key_strobe = st; key_val = v;
        @(posedge clk);
        #1 model = ref_next(model, r, st, v);
        #2;
        n_run++;
        if (step_sel !== model[2:0] || door_open !== model[3]) begin
            n_fail++;
            $display("FAIL %s: sel=%b open=%b expected sel=%b open=%b",
                     tag, step_sel, door_open, model[2:0], model[3]);
        end
    endtask

    task automatic enter_prefix(input int k, input string tag);
        for (int i = 0; i < k; i++) cycle(0, 1, code[i], tag);
    endtask

    initial begin
        code[0] = 4'd3; code[1] = 4'd4; code[2] = 4'd2;  // R9 defaults

        // R1 reset state
        cycle(1, 0, 0, "R1");
        cycle(1, 1, 4'd3, "R2");
        cycle(0, 0, 0, "R1");

        // R4 correct code, with R3 idle gaps in each step
        cycle(1, 0, 0, "R1");
        for (int i = 0; i < 3; i++) begin
            for (int g = 0; g < 3; g++) cycle(0, 0, code[i] ^ 4'hF, "R3");
            cycle(0, 1, code[i], "R4");
        end

        // R6 open sticky under every value
        for (int v = 0; v < 16; v++) cycle(0, 1, v[3:0], "R6");
        cycle(0, 0, 0, "R6");

        // R5 every wrong value at every step, then R7 stickiness
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 16; v++) begin
                if (v[3:0] == code[s]) continue;
                cycle(1, 0, 0, "R1");
                enter_prefix(s, "R4");
                cycle(0, 1, v[3:0], "R5");
                if (v == 0) begin
                    enter_prefix(3, "R7");
                    cycle(0, 0, 0, "R7");
                end
            end
        end

        // R2 reset colliding with a matching strobe in every state
        for (int s = 0; s < 5; s++) begin
            cycle(1, 0, 0, "R1");
            if (s < 4) enter_prefix(s, "R4");
            else cycle(0, 1, 4'd0, "R5");
            cycle(1, 1, (s < 3) ? code[s] : 4'd3, "R2");
            cycle(0, 0, 0, "R2");
        end

        // R8 check encoding relation at each reachable state
        cycle(1, 0, 0, "R8");
        for (int i = 0; i < 3; i++) cycle(0, 1, code[i], "R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule